// File: doc/BRIEF.md
# Two-Level Radix Page-Table Walker

The walker turns a 64-bit effective address into a physical address. For each lookup it takes the effective address and a process identifier. It then reads four doublewords from memory, one at a time. The first read is a partition-table entry at a base supplied on a port. That entry gives the base of the process table. The second read is the process-table entry, which holds the root descriptor. The third read is the top-level directory entry. The fourth read is the leaf page-table entry. Each doubleword is held in memory with its most significant byte first, so the walker reverses the byte order of every doubleword before it decodes it.

The walker handles one lookup at a time. `busy` stays high from the cycle the request is accepted until the result has been delivered. The result is a one-cycle pulse. It carries one of two outcomes:
- the leaf entry together with the physical address, which joins the physical page number to the 4 KB page offset of the effective address; or
- a fault flag, meaning that no translation exists.

Permission checking, translation caching and the memory are outside this block.

FSM states: `S_IDLE`, `S_PTAB_REQ`, `S_PTAB_WAIT`, `S_PROC_REQ`, `S_PROC_WAIT`, `S_DIR_REQ`, `S_DIR_WAIT`, `S_LEAF_REQ`, `S_LEAF_WAIT`, `S_DONE`.

Transitions:
- `S_IDLE`→`S_PTAB_REQ` when a request with an in-range address arrives.
- `S_IDLE`→`S_DONE` when the address is out of range.
- Each `*_REQ`→`*_WAIT` when the read is accepted (`mrd_ready`).
- Each `*_WAIT`→the next `*_REQ` when a good entry returns.
- Each `*_WAIT`→`S_DONE` when a bad entry returns, and always after the leaf read.
- `S_DONE`→`S_IDLE` after one cycle.

Top module: `radix_walker`

## Requirements
- R1: After reset, `busy`, `mrd_valid` and `res_valid` are all low.
- R2: A full walk issues exactly four reads, in this order:
  - `tbl_base`+8;
  - process base + 16×PID;
  - root base + 8×EA[30:21];
  - directory base + 8×EA[20:12].
- R3: Every doubleword is byte-reversed. Bits 7:0 of `mrd_rsp_data` become bits 63:56 of the entry, and so on for each byte.
- R4: Every base that the walker follows is the decoded entry ANDed with 0x00FF_FFFF_FFFF_FF00.
- R5: The root descriptor's low 5 bits must equal 10. Any other value ends the walk with a fault after the second read.
- R6: A directory entry must have bit 63 set, bit 62 clear and low 5 bits equal to 9. Otherwise the walk ends with a fault after the third read.
- R7: A leaf entry must have both bit 63 and bit 62 set. When it does, `res_pte` is the decoded entry and `res_pa` = {8'h00, entry[55:12], EA[11:0]}. Otherwise the result is a fault with zero `res_pte` and zero `res_pa`.
- R8: An all-zero entry at any of the four reads ends the walk with a fault, and no further read is issued.
- R9: An effective address with any of bits 63:31 set faults without any memory read.
- R10: While `mrd_valid` is high and `mrd_ready` is low, `mrd_addr` holds steady. At most one read is outstanding.
- R11: `busy` rises in the cycle after the request is accepted. Requests that arrive while the walker is busy are ignored.
- R12: `res_valid` is a one-cycle pulse. With zero-wait memory it comes in the 9th cycle after acceptance for a full walk. It comes in the 3rd, 5th or 7th cycle for a fault at the first, second or third read, and in the 1st cycle for an out-of-range address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request, taken when not busy |
| req_ea | input | 64 | Effective address |
| req_pid | input | PID_W | Process identifier |
| tbl_base | input | 64 | Partition table base address |
| busy | output | 1 | Walk in progress |
| mrd_valid | output | 1 | Memory read request valid |
| mrd_ready | input | 1 | Memory accepts the read request |
| mrd_addr | output | 64 | Byte address of the doubleword |
| mrd_rsp_valid | input | 1 | Read data valid |
| mrd_rsp_data | input | 64 | Read data, big-endian doubleword |
| res_valid | output | 1 | Result pulse |
| res_fault | output | 1 | No translation |
| res_pte | output | 64 | Decoded leaf entry |
| res_pa | output | 64 | Physical address |

## Verification
The bench's memory model accepts a read on the edge where `mrd_valid` and `mrd_ready` are both high. It returns the data on the following cycle, so each level costs two cycles. A full walk therefore reports in the 9th cycle after the accepting edge. Faults at the first, second or third read report in the 3rd, 5th or 7th cycle, and an out-of-range address reports in the 1st.

Each scenario counts falling edges from the accepting edge until `res_valid` is seen. It compares that count with the expected count and then checks that the pulse is gone on the next falling edge. It also compares the number and the addresses of the reads with the expected sequence. A stalled-ready scenario checks the result and the addresses but not the latency.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PTAB_REQ,
        S_PTAB_WAIT,
        S_PROC_REQ,
        S_PROC_WAIT,
        S_DIR_REQ,
        S_DIR_WAIT,
        S_LEAF_REQ,
        S_LEAF_WAIT,
        S_DONE
    } walk_state_e;

    localparam logic [63:0] NEXT_BASE_MASK = 64'h00FF_FFFF_FFFF_FF00;

    typedef struct packed {
        logic        zero;
        logic        vld;
        logic        leaf;
        logic [4:0]  size;
        logic [63:0] base;
    } entry_info_t;

endpackage

// File: rtl/ptw_byteswap.sv
module ptw_byteswap #(
    parameter int DW = 64
) (
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    localparam int NBYTES = DW / 8;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign dout[8*b +: 8] = din[8*(NBYTES-1-b) +: 8];
    end
endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode
    import ptw_pkg::*;
(
    input  logic [63:0] entry,
    output entry_info_t info
);
    always_comb begin
        info.zero = (entry == 64'd0);
        info.vld  = entry[63];
        info.leaf = entry[62];
        info.size = entry[4:0];
        info.base = entry & NEXT_BASE_MASK;
    end
endmodule

// File: rtl/ptw_index.sv
module ptw_index #(
    parameter int PAGE_SHIFT = 12,
    parameter int TOP_W      = 10,
    parameter int LEAF_W     = 9
) (
    input  logic [63:0]           ea,
    output logic [TOP_W-1:0]      top_idx,
    output logic [LEAF_W-1:0]     leaf_idx,
    output logic [PAGE_SHIFT-1:0] page_off,
    output logic                  out_of_range
);
    localparam int LEAF_LO = PAGE_SHIFT;
    localparam int TOP_LO  = PAGE_SHIFT + LEAF_W;
    localparam int SPAN    = PAGE_SHIFT + LEAF_W + TOP_W;

    assign page_off     = ea[PAGE_SHIFT-1:0];
    assign leaf_idx     = ea[LEAF_LO +: LEAF_W];
    assign top_idx      = ea[TOP_LO +: TOP_W];
    assign out_of_range = |ea[63:SPAN];
endmodule

// File: rtl/radix_walker.sv
module radix_walker
    import ptw_pkg::*;
#(
    parameter int PID_W      = 20,
    parameter int PAGE_SHIFT = 12,
    parameter int TOP_W      = 10,
    parameter int LEAF_W     = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [63:0]      req_ea,
    input  logic [PID_W-1:0] req_pid,
    input  logic [63:0]      tbl_base,
    output logic             busy,
    output logic             mrd_valid,
    input  logic             mrd_ready,
    output logic [63:0]      mrd_addr,
    input  logic             mrd_rsp_valid,
    input  logic [63:0]      mrd_rsp_data,
    output logic             res_valid,
    output logic             res_fault,
    output logic [63:0]      res_pte,
    output logic [63:0]      res_pa
);
    localparam int          DW_SHIFT   = 3;
    localparam int          PROC_SHIFT = 4;
    localparam logic [63:0] DW_BYTES   = 64'd1 << DW_SHIFT;
    localparam logic [4:0]  TOP_SZ     = 5'(TOP_W);
    localparam logic [4:0]  LEAF_SZ    = 5'(LEAF_W);
    localparam int          PPN_W      = 56 - PAGE_SHIFT;

    walk_state_e state, nxt;

    logic [63:0]      ea_q;
    logic [PID_W-1:0] pid_q;
    logic [63:0]      addr_q;
    logic [63:0]      pte_q;
    logic             fault_q;

    logic [63:0]           swapped;
    entry_info_t           ent;
    logic [63:0]           ea_sel;
    logic [TOP_W-1:0]      top_idx;
    logic [LEAF_W-1:0]     leaf_idx;
    logic [PAGE_SHIFT-1:0] page_off;
    logic                  ea_oor;
    logic                  bad;
    logic [63:0]           pid_off, top_off, leaf_off;

    assign ea_sel = (state == S_IDLE) ? req_ea : ea_q;

    ptw_byteswap #(.DW(64)) u_swap (
        .din  (mrd_rsp_data),
        .dout (swapped)
    );

    ptw_entry_decode u_dec (
        .entry (swapped),
        .info  (ent)
    );

    ptw_index #(
        .PAGE_SHIFT (PAGE_SHIFT),
        .TOP_W      (TOP_W),
        .LEAF_W     (LEAF_W)
    ) u_idx (
        .ea           (ea_sel),
        .top_idx      (top_idx),
        .leaf_idx     (leaf_idx),
        .page_off     (page_off),
        .out_of_range (ea_oor)
    );

    assign pid_off  = {{(64-PID_W-PROC_SHIFT){1'b0}}, pid_q, {PROC_SHIFT{1'b0}}};
    assign top_off  = {{(64-TOP_W-DW_SHIFT){1'b0}}, top_idx, {DW_SHIFT{1'b0}}};
    assign leaf_off = {{(64-LEAF_W-DW_SHIFT){1'b0}}, leaf_idx, {DW_SHIFT{1'b0}}};

    // Entry acceptance rule per level
    always_comb begin
        unique case (state)
            S_PTAB_WAIT: bad = ent.zero;
            S_PROC_WAIT: bad = ent.zero || (ent.size != TOP_SZ);
            S_DIR_WAIT:  bad = !ent.vld || ent.leaf || (ent.size != LEAF_SZ);
            S_LEAF_WAIT: bad = !(ent.vld && ent.leaf);
            default:     bad = 1'b0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:      if (req_valid) nxt = ea_oor ? S_DONE : S_PTAB_REQ;
            S_PTAB_REQ:  if (mrd_ready) nxt = S_PTAB_WAIT;
            S_PTAB_WAIT: if (mrd_rsp_valid) nxt = bad ? S_DONE : S_PROC_REQ;
            S_PROC_REQ:  if (mrd_ready) nxt = S_PROC_WAIT;
            S_PROC_WAIT: if (mrd_rsp_valid) nxt = bad ? S_DONE : S_DIR_REQ;
            S_DIR_REQ:   if (mrd_ready) nxt = S_DIR_WAIT;
            S_DIR_WAIT:  if (mrd_rsp_valid) nxt = bad ? S_DONE : S_LEAF_REQ;
            S_LEAF_REQ:  if (mrd_ready) nxt = S_LEAF_WAIT;
            S_LEAF_WAIT: if (mrd_rsp_valid) nxt = S_DONE;
            S_DONE:      nxt = S_IDLE;
            default:     nxt = S_IDLE;
        endcase
    end

    // Walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ea_q    <= '0;
            pid_q   <= '0;
            addr_q  <= '0;
            pte_q   <= '0;
            fault_q <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) begin
                    ea_q    <= req_ea;
                    pid_q   <= req_pid;
                    addr_q  <= tbl_base + DW_BYTES;
                    pte_q   <= '0;
                    fault_q <= ea_oor;
                end
                S_PTAB_WAIT: if (mrd_rsp_valid) begin
                    fault_q <= bad;
                    addr_q  <= ent.base + pid_off;
                end
                S_PROC_WAIT: if (mrd_rsp_valid) begin
                    fault_q <= bad;
                    addr_q  <= ent.base + top_off;
                end
                S_DIR_WAIT: if (mrd_rsp_valid) begin
                    fault_q <= bad;
                    addr_q  <= ent.base + leaf_off;
                end
                S_LEAF_WAIT: if (mrd_rsp_valid) begin
                    fault_q <= bad;
                    if (!bad) pte_q <= swapped;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy      = (state != S_IDLE);
        mrd_valid = 1'b0;
        unique case (state)
            S_PTAB_REQ, S_PROC_REQ, S_DIR_REQ, S_LEAF_REQ: mrd_valid = 1'b1;
            default: mrd_valid = 1'b0;
        endcase
        mrd_addr  = addr_q;
        res_valid = (state == S_DONE);
        res_fault = fault_q;
        res_pte   = fault_q ? 64'd0 : pte_q;
        res_pa    = fault_q ? 64'd0
                            : {8'h00, pte_q[55:PAGE_SHIFT], page_off};
    end

    logic unused_ok;
    assign unused_ok = ^{ea_q[63:56], PPN_W[0]};
endmodule

// File: rtl/radix_walker_chk.sv
module radix_walker_chk #(
    parameter int PID_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [PID_W-1:0] req_pid,
    input logic             busy,
    input logic             mrd_valid,
    input logic             mrd_ready,
    input logic [63:0]      mrd_addr,
    input logic             res_valid,
    input logic             res_fault,
    input logic [63:0]      res_pte,
    input logic [63:0]      res_pa
);
    assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mrd_valid && !mrd_ready) |=> (mrd_valid && $stable(mrd_addr)));

    assert_rd_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mrd_valid |-> (mrd_addr[2:0] == 3'd0));

    assert_rd_when_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mrd_valid |-> busy);

    assert_accept_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    assert_res_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    assert_no_rd_at_res_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !mrd_valid);

    assert_leaf_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_fault) |-> (res_pte[63:62] == 2'b11));

    assert_fault_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault) |-> (res_pte == 64'd0 && res_pa == 64'd0));

    logic unused_ok;
    assign unused_ok = ^req_pid;
endmodule

bind radix_walker radix_walker_chk #(.PID_W(PID_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_pid   (req_pid),
    .busy      (busy),
    .mrd_valid (mrd_valid),
    .mrd_ready (mrd_ready),
    .mrd_addr  (mrd_addr),
    .res_valid (res_valid),
    .res_fault (res_fault),
    .res_pte   (res_pte),
    .res_pa    (res_pa)
);

// File: tb/radix_walker_tb_top.sv
module radix_walker_tb_top;
    localparam int PID_W = 20;
    localparam logic [63:0] PTB      = 64'h13000;
    localparam logic [63:0] PROC     = 64'h12000;
    localparam logic [63:0] ROOT     = 64'h10000;
    localparam logic [63:0] ROOT_B   = 64'h30000;
    localparam logic [63:0] DIR0     = 64'h14000;
    localparam logic [63:0] DIR8     = 64'h15000;
    localparam logic [63:0] DIR5     = 64'h16000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [63:0] req_ea = '0;
    logic [PID_W-1:0] req_pid = '0;
    logic [63:0] tbl_base = PTB;
    logic busy, mrd_valid, mrd_ready, mrd_rsp_valid;
    logic [63:0] mrd_addr, mrd_rsp_data;
    logic res_valid, res_fault;
    logic [63:0] res_pte, res_pa;

    int checks = 0;
    int fails = 0;
    bit stall = 1'b0;
    int nreads = 0;
    logic [63:0] rd_log [4];
    logic [63:0] mem [logic [63:0]];

    always #5 clk = ~clk;

    radix_walker #(.PID_W(PID_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea),
        .req_pid(req_pid), .tbl_base(tbl_base), .busy(busy),
        .mrd_valid(mrd_valid), .mrd_ready(mrd_ready), .mrd_addr(mrd_addr),
        .mrd_rsp_valid(mrd_rsp_valid), .mrd_rsp_data(mrd_rsp_data),
        .res_valid(res_valid), .res_fault(res_fault), .res_pte(res_pte),
        .res_pa(res_pa)
    );

    function automatic logic [63:0] be(input logic [63:0] v);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) r[8*i +: 8] = v[56-8*i +: 8];
        return r;
    endfunction

    function automatic logic [63:0] rd_word(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'd0;
    endfunction

    task automatic put(input logic [63:0] a, input logic [63:0] v);
        mem[a] = be(v);
    endtask

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory model: accept on valid&ready, reply one cycle later
    initial begin
        bit pend = 1'b0;
        logic [63:0] pa;
        pa = '0;
        mrd_ready = 1'b1;
        mrd_rsp_valid = 1'b0;
        mrd_rsp_data = '0;
        forever begin
            @(negedge clk);
            mrd_rsp_valid = pend;
            mrd_rsp_data  = pend ? rd_word(pa) : 64'd0;
            pend = 1'b0;
            mrd_ready = stall ? ~mrd_ready : 1'b1;
            if (mrd_valid && mrd_ready) begin
                pend = 1'b1;
                pa = mrd_addr;
                if (nreads < 4) rd_log[nreads] = mrd_addr;
                nreads++;
            end
        end
    end

    // One walk: exp_lat < 0 skips the latency check; poke drives a request mid-walk
    task automatic walk(input string req, input logic [63:0] ea, input int pid,
                        input logic [63:0] root, input logic [63:0] dir,
                        input bit exp_fault, input int exp_reads, input int exp_lat,
                        input logic [63:0] exp_pte, input bit poke);
        int n;
        logic [63:0] ex [4];
        ex[0] = tbl_base + 64'd8;
        ex[1] = PROC + 64'(pid) * 16;
        ex[2] = root + {ea[30:21], 3'b000};
        ex[3] = dir + {ea[20:12], 3'b000};
        @(negedge clk);
        nreads = 0;
        req_valid = 1'b1; req_ea = ea; req_pid = PID_W'(pid);
        @(posedge clk);
        n = 0;
        while (n < 100) begin
            @(negedge clk);
            n++;
            if (n == 1) req_valid = 1'b0;
            if (poke && n == 3) begin
                req_valid = 1'b1; req_ea = 64'h1_0000_0000; req_pid = '0;
            end
            if (poke && n == 4) req_valid = 1'b0;
            if (n == 1 && exp_lat != 1) chk(busy == 1'b1, {req, " R11 busy"}, 64'(busy), 64'd1);
            if (res_valid) break;
        end
        if (exp_lat > 0) chk(n == exp_lat, {req, " R12 latency"}, 64'(n), 64'(exp_lat));
        chk(res_valid == 1'b1, {req, " R12 result seen"}, 64'(res_valid), 64'd1);
        chk(res_fault == exp_fault, {req, " fault"}, 64'(res_fault), 64'(exp_fault));
        if (!exp_fault) begin
            chk(res_pte == exp_pte, {req, " R7 pte"}, res_pte, exp_pte);
            chk(res_pa == {8'h00, exp_pte[55:12], ea[11:0]}, {req, " R7 pa"},
                res_pa, {8'h00, exp_pte[55:12], ea[11:0]});
        end
        chk(nreads == exp_reads, {req, " R2 read count"}, 64'(nreads), 64'(exp_reads));
        for (int i = 0; i < 4; i++)
            if (i < exp_reads && i < nreads)
                chk(rd_log[i] == ex[i], {req, " R2 read address"}, rd_log[i], ex[i]);
        @(negedge clk);
        chk(res_valid == 1'b0, {req, " R12 pulse width"}, 64'(res_valid), 64'd0);
        chk(busy == 1'b0, {req, " R11 idle after"}, 64'(busy), 64'd0);
    endtask

    task automatic t_reset;
        chk(busy == 1'b0 && mrd_valid == 1'b0 && res_valid == 1'b0, "R1 reset outputs",
            {61'd0, busy, mrd_valid, res_valid}, 64'd0);
    endtask

    task automatic t_basic;
        walk("R3 basic", 64'h124108, 1, ROOT, DIR0, 1'b0, 4, 9,
             64'hC000_0000_0000_8186, 1'b0);
    endtask

    task automatic t_second_dir;
        walk("R4 second directory", 64'h1124010, 1, ROOT, DIR8, 1'b0, 4, 9,
             64'hC000_0000_0009_A105, 1'b0);
    endtask

    task automatic t_stall;
        stall = 1'b1;
        walk("R10 stalled ready", 64'h124ABC, 1, ROOT, DIR0, 1'b0, 4, -1,
             64'hC000_0000_0000_8186, 1'b0);
        stall = 1'b0;
    endtask

    task automatic t_faults;
        walk("R8 zero leaf", 64'h123000, 1, ROOT, DIR0, 1'b1, 4, 9, 64'd0, 1'b0);
        walk("R8 zero directory", 64'h400000, 1, ROOT, DIR0, 1'b1, 3, 7, 64'd0, 1'b0);
        walk("R8 zero process entry", 64'h124000, 2, ROOT, DIR0, 1'b1, 2, 5, 64'd0, 1'b0);
        walk("R5 root size", 64'h124000, 3, ROOT_B, DIR0, 1'b1, 2, 5, 64'd0, 1'b0);
        walk("R6 directory leaf bit", 64'h600000, 1, ROOT, DIR0, 1'b1, 3, 7, 64'd0, 1'b0);
        walk("R6 directory size", 64'h800000, 1, ROOT, DIR0, 1'b1, 3, 7, 64'd0, 1'b0);
        walk("R7 leaf without bit 62", 64'hA05000, 1, ROOT, DIR5, 1'b1, 4, 9, 64'd0, 1'b0);
        walk("R9 high address", 64'h8000_0000, 1, ROOT, DIR0, 1'b1, 0, 1, 64'd0, 1'b0);
        tbl_base = 64'h20000;
        walk("R8 zero partition entry", 64'h124000, 1, ROOT, DIR0, 1'b1, 1, 3, 64'd0, 1'b0);
        tbl_base = PTB;
    endtask

    task automatic t_busy_ignore;
        walk("R11 request while busy", 64'h124208, 1, ROOT, DIR0, 1'b0, 4, 9,
             64'hC000_0000_0000_8186, 1'b1);
    endtask

    initial begin
        put(PTB + 8, PROC);
        put(PROC + 16, ROOT | 64'd10);
        put(PROC + 48, ROOT_B | 64'd9);
        put(ROOT + 8*0, 64'h8000_0000_0000_0000 | DIR0 | 64'd9);
        put(ROOT + 8*8, 64'h8000_0000_0000_0000 | DIR8 | 64'd9);
        put(ROOT + 8*3, 64'hC000_0000_0000_0000 | 64'h17000 | 64'd9);
        put(ROOT + 8*4, 64'h8000_0000_0000_0000 | 64'h18000 | 64'd8);
        put(ROOT + 8*5, 64'h8000_0000_0000_0000 | DIR5 | 64'd9);
        put(DIR0 + 8*9'h124, 64'hC000_0000_0000_8186);
        put(DIR8 + 8*9'h124, 64'hC000_0000_0009_A105);
        put(DIR5 + 8*9'h005, 64'h8000_0000_0000_B186);
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_basic;
        t_second_dir;
        t_stall;
        t_faults;
        t_busy_ignore;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule